// File: doc/BRIEF.md
# Voice Codec Bus-Side Buffering

This block sits between a peripheral register bus and the converter core of a voice codec. Software or a DMA engine writes delta-modulated bitstream words into an input FIFO. The core takes those words one bit at a time, starting with the oldest bit. Bitstream words that the core produces go into an output FIFO, and the bus reads them from there. Linear PCM samples cross in each direction through a double-buffered register pair, which gives the servicing agent a full sample period to respond.

A status word reports the live service requests, a set of sticky error flags and a configuration error. Reading the status word clears the sticky flags. Each request group (bitstream or PCM) can raise the shared interrupt or assert per-direction DMA requests. A debug freeze input halts every buffer movement on the core side and holds the sticky flags across status reads.

Register addresses: 0 bitstream in (write), 1 bitstream out (read), 2 PCM in (write), 3 PCM out (read), 4 control (read/write), 5 status (read).

Top module: `codec_buf_top`

## Requirements
- R1: After reset, status reads 0x0005, the PCM out register reads 0, and `irq_o` and `dma_req_o` are low.
- R2: The bitstream input FIFO holds 8 words. Status bit 0 is set while at least one entry is free. A bus write to a full FIFO is dropped and sets sticky status bit 4.
- R3: `core_bit_o` presents bit 15 of each word first and bit 0 last. Each `core_bit_rd_i` pulse advances one bit, and the next word is loaded without a request. A pulse while `core_bit_valid_o` is low sets sticky status bit 5.
- R4: The bitstream output FIFO holds 8 words, and bus reads return them in push order. Status bit 1 is set while the FIFO holds a word. A core push into a full FIFO is dropped and sets sticky bit 6. A bus read of an empty FIFO sets sticky bit 7.
- R5: When the output FIFO is full, a core push and a bus read in the same cycle are both accepted, and no overflow is flagged.
- R6: A PCM-in write fills the holding stage, and `core_pcm_take_i` moves it to `core_pcm_in_o`. Status bit 2 is set while the holding stage is empty. A write while the holding stage is full overwrites it and sets sticky bit 8.
- R7: A core PCM put loads the PCM out register and sets status bit 3. A bus read of PCM out clears bit 3.
- R8: While `freeze_i` is high, the serializer loads no word from the input FIFO, and core bitstream pushes and PCM puts are ignored.
- R9: A status read returns the flags as they were and then clears sticky bits 4 to 8. While frozen, the read clears nothing.
- R10: Control bits are: 0 bitstream irq enable, 1 bitstream DMA in, 2 bitstream DMA out, 3 PCM irq enable, 4 PCM DMA in, 5 PCM DMA out. `dma_req_o[3:0]` = {PCM out ready, PCM in empty, bitstream out avail, bitstream in space}, each gated by its DMA enable. `irq_o` is raised by a group's requests when that group's irq enable is set.
- R11: Enabling a group's interrupt together with either of its DMA directions sets status bit 9. DMA then takes priority, and that group raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Debug freeze |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (side effects at clock edge) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| core_bit_rd_i | input | 1 | Core consumes one bitstream bit |
| core_bit_o | output | 1 | Current bitstream bit |
| core_bit_valid_o | output | 1 | A bit is available |
| core_bs_push_i | input | 1 | Core pushes a bitstream word |
| core_bs_word_i | input | 16 | Pushed bitstream word |
| core_pcm_take_i | input | 1 | Core takes the next PCM-in sample |
| core_pcm_in_o | output | 16 | PCM-in sample presented to the core |
| core_pcm_put_i | input | 1 | Core delivers a PCM-out sample |
| core_pcm_word_i | input | 16 | Delivered PCM-out sample |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 4 | DMA requests per direction |

## Verification
The core push into the output FIFO and the bus read that pops it can land on the same clock edge. The case that matters is a full FIFO, where a wrong overflow decision either loses a word or raises a false error. The bench fills the FIFO, then drives a core push and a bus read of the bitstream-out register in one cycle. It passes only if that read returns the oldest word, status bit 6 stays clear, and the next eight reads return the remaining words with the new one last. A second overlap, a status read while a sticky flag is being held under freeze, is judged by reading the status twice.

// File: rtl/codec_buf_pkg.sv
package codec_buf_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_BS_IN   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_BS_OUT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PCM_IN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PCM_OUT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd5;

  localparam int unsigned CTRL_W   = 6;
  localparam int unsigned STICKY_W = 5;

  typedef struct packed {
    logic pcm_dma_out;
    logic pcm_dma_in;
    logic pcm_irq;
    logic bs_dma_out;
    logic bs_dma_in;
    logic bs_irq;
  } ctrl_t;

  typedef struct packed {
    logic pcm_in_ovr;
    logic bs_out_udf;
    logic bs_out_ovf;
    logic bs_bit_udf;
    logic bs_in_ovf;
  } sticky_t;
endpackage

// File: rtl/cb_fifo.sv
module cb_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o,
  output logic          drop_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop, full, empty;

  assign full    = (level_q == LW'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_pop  = pop_i && !empty;
  // a pop in the same cycle frees the slot for a push into a full FIFO
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && !do_push;
  assign data_o  = mem_q[rptr_q];
  assign level_o = level_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  // R2
  fifo_level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));

  // R4
  fifo_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> (level_q == '0));
endmodule

// File: rtl/cb_bit_unpack.sv
module cb_bit_unpack #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         freeze_i,
  input  logic         word_valid_i,
  input  logic [W-1:0] word_i,
  output logic         word_pop_o,
  input  logic         bit_rd_i,
  output logic         bit_o,
  output logic         bit_valid_o,
  output logic         udf_o
);
  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          load;

  assign bit_valid_o = (cnt_q != '0);
  assign load        = !bit_valid_o && word_valid_i && !freeze_i;
  assign word_pop_o  = load;
  assign bit_o       = sr_q[W-1];   // earliest bit sits in the MSB
  assign udf_o       = bit_rd_i && !bit_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= word_i;
      cnt_q <= CW'(W);
    end else if (bit_rd_i && bit_valid_o) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  unpack_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W));

  // R3
  unpack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_rd_i) |=> (bit_valid_o && $stable(sr_q)));
endmodule

// File: rtl/cb_pcm_in.sv
module cb_pcm_in #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         hold_full_o,
  output logic         ovr_o
);
  logic [W-1:0] hold_q, act_q;
  logic         full_q;

  assign hold_full_o = full_q;
  assign data_o      = act_q;
  assign ovr_o       = wr_i && full_q && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take_i && full_q) act_q <= hold_q;
      if (wr_i) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6
  pcm_hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_q && !take_i) |=> (full_q && hold_q == $past(wdata_i)));
endmodule

// File: rtl/codec_buf_top.sv
module codec_buf_top
  import codec_buf_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned BS_DEPTH = 8,
  localparam int unsigned LW      = $clog2(BS_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic              core_bit_rd_i,
  output logic              core_bit_o,
  output logic              core_bit_valid_o,
  input  logic              core_bs_push_i,
  input  logic [W-1:0]      core_bs_word_i,
  input  logic              core_pcm_take_i,
  output logic [W-1:0]      core_pcm_in_o,
  input  logic              core_pcm_put_i,
  input  logic [W-1:0]      core_pcm_word_i,
  output logic              irq_o,
  output logic [3:0]        dma_req_o
);
  logic wr_bs_in, rd_bs_out, wr_pcm_in, rd_pcm_out, wr_ctrl, rd_stat;
  assign wr_bs_in   = bus_we_i && (bus_addr_i == ADR_BS_IN);
  assign wr_pcm_in  = bus_we_i && (bus_addr_i == ADR_PCM_IN);
  assign wr_ctrl    = bus_we_i && (bus_addr_i == ADR_CTRL);
  assign rd_bs_out  = bus_re_i && (bus_addr_i == ADR_BS_OUT);
  assign rd_pcm_out = bus_re_i && (bus_addr_i == ADR_PCM_OUT);
  assign rd_stat    = bus_re_i && (bus_addr_i == ADR_STAT);

  // bitstream in path
  logic [W-1:0]  in_head;
  logic [LW-1:0] in_level;
  logic          in_drop, unp_pop, unp_udf;

  cb_fifo #(.W(W), .DEPTH(BS_DEPTH)) u_bs_in (
    .clk_i, .rst_ni,
    .push_i (wr_bs_in),
    .data_i (bus_wdata_i),
    .pop_i  (unp_pop),
    .data_o (in_head),
    .level_o(in_level),
    .drop_o (in_drop)
  );

  cb_bit_unpack #(.W(W)) u_unpack (
    .clk_i, .rst_ni,
    .freeze_i,
    .word_valid_i(in_level != '0),
    .word_i      (in_head),
    .word_pop_o  (unp_pop),
    .bit_rd_i    (core_bit_rd_i),
    .bit_o       (core_bit_o),
    .bit_valid_o (core_bit_valid_o),
    .udf_o       (unp_udf)
  );

  // bitstream out path
  logic [W-1:0]  out_head;
  logic [LW-1:0] out_level;
  logic          out_drop, core_push_ok, out_empty;

  assign core_push_ok = core_bs_push_i && !freeze_i;
  assign out_empty    = (out_level == '0);

  cb_fifo #(.W(W), .DEPTH(BS_DEPTH)) u_bs_out (
    .clk_i, .rst_ni,
    .push_i (core_push_ok),
    .data_i (core_bs_word_i),
    .pop_i  (rd_bs_out),
    .data_o (out_head),
    .level_o(out_level),
    .drop_o (out_drop)
  );

  // PCM in path
  logic pcm_hold_full, pcm_ovr;

  cb_pcm_in #(.W(W)) u_pcm_in (
    .clk_i, .rst_ni,
    .wr_i       (wr_pcm_in),
    .wdata_i    (bus_wdata_i),
    .take_i     (core_pcm_take_i),
    .data_o     (core_pcm_in_o),
    .hold_full_o(pcm_hold_full),
    .ovr_o      (pcm_ovr)
  );

  // PCM out path
  logic [W-1:0] pcm_out_q;
  logic         pcm_out_rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_out_q     <= '0;
      pcm_out_rdy_q <= 1'b0;
    end else if (core_pcm_put_i && !freeze_i) begin
      pcm_out_q     <= core_pcm_word_i;
      pcm_out_rdy_q <= 1'b1;
    end else if (rd_pcm_out) begin
      pcm_out_rdy_q <= 1'b0;
    end
  end

  // control and status
  ctrl_t   ctrl_q;
  sticky_t sticky_q, sticky_set;
  logic    cfg_err, bs_grp_dma, pcm_grp_dma;
  logic    req_bs_in, req_bs_out, req_pcm_in, req_pcm_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
  end

  assign sticky_set.bs_in_ovf  = in_drop;
  assign sticky_set.bs_bit_udf = unp_udf;
  assign sticky_set.bs_out_ovf = out_drop;
  assign sticky_set.bs_out_udf = rd_bs_out && out_empty;
  assign sticky_set.pcm_in_ovr = pcm_ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= ((rd_stat && !freeze_i) ? sticky_t'('0) : sticky_q) | sticky_set;
  end

  assign req_bs_in   = (in_level != LW'(BS_DEPTH));
  assign req_bs_out  = !out_empty;
  assign req_pcm_in  = !pcm_hold_full;
  assign req_pcm_out = pcm_out_rdy_q;

  assign bs_grp_dma  = ctrl_q.bs_dma_in || ctrl_q.bs_dma_out;
  assign pcm_grp_dma = ctrl_q.pcm_dma_in || ctrl_q.pcm_dma_out;
  assign cfg_err     = (ctrl_q.bs_irq && bs_grp_dma) || (ctrl_q.pcm_irq && pcm_grp_dma);

  assign dma_req_o = {req_pcm_out && ctrl_q.pcm_dma_out,
                      req_pcm_in  && ctrl_q.pcm_dma_in,
                      req_bs_out  && ctrl_q.bs_dma_out,
                      req_bs_in   && ctrl_q.bs_dma_in};

  // DMA enables mask the interrupt of their group
  assign irq_o = (ctrl_q.bs_irq  && !bs_grp_dma  && (req_bs_in  || req_bs_out)) ||
                 (ctrl_q.pcm_irq && !pcm_grp_dma && (req_pcm_in || req_pcm_out));

  logic [W-1:0] stat_word;
  assign stat_word = W'({cfg_err, sticky_q, req_pcm_out, req_pcm_in, req_bs_out, req_bs_in});

  always_comb begin
    case (bus_addr_i)
      ADR_BS_OUT:  bus_rdata_o = out_head;
      ADR_PCM_OUT: bus_rdata_o = pcm_out_q;
      ADR_CTRL:    bus_rdata_o = W'(ctrl_q);
      ADR_STAT:    bus_rdata_o = stat_word;
      default:     bus_rdata_o = '0;
    endcase
  end

  // R8
  freeze_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_bs_in) |=> $stable(in_level));

  // R8
  freeze_pcm_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(pcm_out_q));

  // R9
  freeze_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && rd_stat) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R11
  dma_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.bs_irq && ctrl_q.bs_dma_in && !ctrl_q.pcm_irq) |-> !irq_o);
endmodule

// File: tb/tb_codec_buf_top.sv
`timescale 1ns/1ps
module tb_codec_buf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        bit_rd = 1'b0, bit_out, bit_valid;
  logic        bs_push = 1'b0;
  logic [15:0] bs_word = '0;
  logic        pcm_take = 1'b0;
  logic [15:0] pcm_in;
  logic        pcm_put = 1'b0;
  logic [15:0] pcm_word = '0;
  logic        irq;
  logic [3:0]  dma;

  int n_cmp = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  codec_buf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .freeze_i(freeze),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .core_bit_rd_i(bit_rd), .core_bit_o(bit_out), .core_bit_valid_o(bit_valid),
    .core_bs_push_i(bs_push), .core_bs_word_i(bs_word),
    .core_pcm_take_i(pcm_take), .core_pcm_in_o(pcm_in),
    .core_pcm_put_i(pcm_put), .core_pcm_word_i(pcm_word),
    .irq_o(irq), .dma_req_o(dma)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic core_push(input logic [15:0] w);
    @(negedge clk); bs_push = 1'b1; bs_word = w;
    @(negedge clk); bs_push = 1'b0;
  endtask

  task automatic get_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      while (!bit_valid) @(negedge clk);
      w[i] = bit_out; bit_rd = 1'b1;
      @(negedge clk); bit_rd = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(3'd5, d);  chk("R1 status", d, 16'h0005);
    bus_rd(3'd3, d);  chk("R1 pcm out", d, 16'h0000);
    chk("R1 irq/dma", {11'd0, irq, dma}, 16'h0000);
  endtask

  task automatic t_bit_order();
    logic [15:0] w, d;
    bus_wr(3'd0, 16'hA5C3);
    get_word(w);      chk("R3 bit order", w, 16'hA5C3);
    @(negedge clk); @(negedge clk);
    chk("R3 valid low", {15'd0, bit_valid}, 16'h0000);
    bit_rd = 1'b1; @(negedge clk); bit_rd = 1'b0;
    bus_rd(3'd5, d);  chk("R3 underflow bit5", d & 16'h0020, 16'h0020);
    bus_rd(3'd5, d);  chk("R9 clear on read", d & 16'h0020, 16'h0000);
  endtask

  task automatic t_in_fifo();
    logic [15:0] w, d;
    freeze = 1'b1;
    for (int i = 0; i < 8; i++) bus_wr(3'd0, 16'h1000 + 16'(i));
    bus_rd(3'd5, d);  chk("R2 no space bit0", d & 16'h0011, 16'h0000);
    bus_wr(3'd0, 16'hDEAD);
    bus_rd(3'd5, d);  chk("R2 overflow bit4", d & 16'h0010, 16'h0010);
    bus_rd(3'd5, d);  chk("R9 frozen keeps bit4", d & 16'h0010, 16'h0010);
    chk("R8 no load while frozen", {15'd0, bit_valid}, 16'h0000);
    freeze = 1'b0;
    bus_rd(3'd5, d);  chk("R9 read returns bit4", d & 16'h0010, 16'h0010);
    bus_rd(3'd5, d);  chk("R9 bit4 cleared", d & 16'h0010, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      get_word(w);    chk("R2 drain order", w, 16'h1000 + 16'(i));
    end
    repeat (3) @(negedge clk);
    chk("R2 dropped word absent", {15'd0, bit_valid}, 16'h0000);
  endtask

  task automatic t_out_fifo();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) core_push(16'h2000 + 16'(i));
    core_push(16'hBAD0);
    bus_rd(3'd5, d);  chk("R4 avail+overflow", d & 16'h0042, 16'h0042);
    for (int i = 0; i < 8; i++) begin
      bus_rd(3'd1, d); chk("R4 read order", d, 16'h2000 + 16'(i));
    end
    bus_rd(3'd5, d);  chk("R4 empty bit1", d & 16'h0002, 16'h0000);
    bus_rd(3'd1, d);
    bus_rd(3'd5, d);  chk("R4 underflow bit7", d & 16'h0080, 16'h0080);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) core_push(16'h3000 + 16'(i));
    @(negedge clk); bs_push = 1'b1; bs_word = 16'hBEEF; re = 1'b1; addr = 3'd1;
    #1 d = rdata;
    @(negedge clk); bs_push = 1'b0; re = 1'b0;
    chk("R5 read head", d, 16'h3000);
    bus_rd(3'd5, d);  chk("R5 no overflow", d & 16'h0040, 16'h0000);
    for (int i = 1; i < 8; i++) begin
      bus_rd(3'd1, d); chk("R5 order", d, 16'h3000 + 16'(i));
    end
    bus_rd(3'd1, d);  chk("R5 new word last", d, 16'hBEEF);
  endtask

  task automatic t_pcm_in();
    logic [15:0] d;
    bus_rd(3'd5, d);  chk("R6 hold empty bit2", d & 16'h0004, 16'h0004);
    bus_wr(3'd2, 16'h1111);
    bus_rd(3'd5, d);  chk("R6 hold full", d & 16'h0004, 16'h0000);
    @(negedge clk); pcm_take = 1'b1; @(negedge clk); pcm_take = 1'b0;
    chk("R6 take", pcm_in, 16'h1111);
    bus_wr(3'd2, 16'h2222);
    bus_wr(3'd2, 16'h3333);
    bus_rd(3'd5, d);  chk("R6 overrun bit8", d & 16'h0104, 16'h0100);
    @(negedge clk); pcm_take = 1'b1; @(negedge clk); pcm_take = 1'b0;
    chk("R6 overwritten sample", pcm_in, 16'h3333);
  endtask

  task automatic t_pcm_out();
    logic [15:0] d;
    @(negedge clk); pcm_put = 1'b1; pcm_word = 16'h4242; @(negedge clk); pcm_put = 1'b0;
    bus_rd(3'd5, d);  chk("R7 ready bit3", d & 16'h0008, 16'h0008);
    bus_rd(3'd3, d);  chk("R7 value", d, 16'h4242);
    bus_rd(3'd5, d);  chk("R7 ready cleared", d & 16'h0008, 16'h0000);
    freeze = 1'b1;
    @(negedge clk); pcm_put = 1'b1; pcm_word = 16'h9999; @(negedge clk); pcm_put = 1'b0;
    core_push(16'h7777);
    bus_rd(3'd3, d);  chk("R8 pcm put ignored", d, 16'h4242);
    bus_rd(3'd5, d);  chk("R8 push ignored", d & 16'h000A, 16'h0000);
    freeze = 1'b0;
  endtask

  task automatic t_irq_dma();
    logic [15:0] d;
    bus_wr(3'd4, 16'h0001);
    #1 chk("R10 bs irq", {11'd0, irq, dma}, 16'h0010);
    bus_wr(3'd4, 16'h0003);
    #1 chk("R11 dma wins", {11'd0, irq, dma}, 16'h0001);
    bus_rd(3'd5, d);  chk("R11 cfg err bit9", d & 16'h0200, 16'h0200);
    bus_wr(3'd4, 16'h0008);
    #1 chk("R10 pcm irq", {11'd0, irq, dma}, 16'h0010);
    bus_wr(3'd4, 16'h0030);
    #1 chk("R10 pcm dma in only", {11'd0, irq, dma}, 16'h0004);
    bus_rd(3'd4, d);  chk("R10 ctrl readback", d, 16'h0030);
    bus_rd(3'd5, d);  chk("R11 legal combo", d & 16'h0200, 16'h0000);
    bus_wr(3'd4, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bit_order();
    t_in_fifo();
    t_out_fifo();
    t_same_cycle();
    t_pcm_in();
    t_pcm_out();
    t_irq_dma();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule